// File: doc/BRIEF.md
# Two's Complement Adder-Subtractor with Signed Overflow

This block is a purely combinational adder-subtractor for two's complement operands of parameterised width (eight bits by default). One chain of full-adder cells does both operations. A single mode input selects between them. To subtract, the second operand is passed through an inverter stage and the carry into the least significant cell is forced high. This adds the two's complement of the second operand without a separate negation step.

The block drives three results:

- the truncated result,
- the raw carry leaving the top cell, which in subtract mode reads as "no borrow" and is not meaningful for signed results,
- a signed overflow flag, taken as the XOR of the carry entering and the carry leaving the most significant cell.

A second result output carries the same value sign-extended to twice the operand width, ready for a wider datapath. The block has no clock and no storage. Outputs follow the inputs after the carry has rippled through every cell.

Top module: `addsub_ovf`

## Requirements
- R1: With sub_mode = 0 (add), result equals (op_a + op_b) modulo 2^WIDTH.
- R2: With sub_mode = 1 (subtract), result equals (op_a - op_b) modulo 2^WIDTH.
- R3: overflow is 1 exactly when the true signed result (op_a + op_b, or op_a - op_b) lies outside -2^(WIDTH-1) to 2^(WIDTH-1)-1, in both modes.
- R4: In add mode, operands whose bit WIDTH-1 differ never raise overflow.
- R5: In add mode, carry_out is 1 exactly when the unsigned sum op_a + op_b is at least 2^WIDTH.
- R6: In subtract mode, carry_out is 1 exactly when op_a is greater than or equal to op_b as unsigned values, and subtracting zero always gives carry_out = 1.
- R7: result_wide holds result in its low WIDTH bits, and every one of its upper WIDTH bits equals result bit WIDTH-1.
- R8: The extreme cases behave as ordinary signed arithmetic. Subtracting the most negative value from zero or from any non-negative value overflows, and a value minus itself gives zero with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend in subtract mode), two's complement |
| op_b | input | WIDTH | Second operand (subtrahend in subtract mode), two's complement |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract |
| result | output | WIDTH | Truncated sum or difference |
| carry_out | output | 1 | Carry leaving the most significant cell |
| overflow | output | 1 | Signed overflow flag |
| result_wide | output | 2*WIDTH | result sign-extended to twice the width |

## Verification
The hardest case to reach from the ports is subtracting the most negative value. Inverting the subtrahend then gives the largest positive pattern, and the forced carry-in pushes the carry chain across the sign cell. Only then do the carry into and the carry out of the top cell disagree with an operand of opposite sign. The bench runs at four bits so it can sweep every operand pair in both modes against integer arithmetic. A table of directed rows pins this case and the other boundary sums (largest positive plus one, most negative minus one, two negatives wrapping positive) so they are named on their own.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_e;

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic bit_a,
    input  logic bit_b,
    input  logic carry_in,
    output logic sum_bit,
    output logic carry_next
);

    always_comb begin
        sum_bit    = bit_a ^ bit_b ^ carry_in;
        carry_next = (bit_a & bit_b) | (bit_a & carry_in) | (bit_b & carry_in);
    end

endmodule

// File: rtl/operand_prep.sv
module operand_prep
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] raw_b,
    input  op_mode_e         mode,
    output logic [WIDTH-1:0] chain_b,
    output logic             chain_cin
);

    always_comb begin
        unique case (mode)
            OP_ADD: begin
                chain_b   = raw_b;
                chain_cin = 1'b0;
            end
            OP_SUB: begin
                chain_b   = ~raw_b;
                chain_cin = 1'b1;
            end
            default: begin
                chain_b   = raw_b;
                chain_cin = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH:0]   carries
);

    assign carries[0] = cin;

    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        fa_cell u_cell (
            .bit_a      (in_a[g]),
            .bit_b      (in_b[g]),
            .carry_in   (carries[g]),
            .sum_bit    (sum[g]),
            .carry_next (carries[g+1])
        );
    end

    // R1 R5: the rippled cells agree with a whole-word addition
    always_comb begin
        chain_sum_chk: assert ({carries[WIDTH], sum} ==
                ({1'b0, in_a} + {1'b0, in_b} + {{WIDTH{1'b0}}, cin}));
    end

endmodule

// File: rtl/sign_widen.sv
module sign_widen #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  narrow,
    output logic [OUT_W-1:0] wide
);

    localparam int PAD_W = OUT_W - IN_W;

    if (PAD_W > 0) begin : g_pad
        assign wide = {{PAD_W{narrow[IN_W-1]}}, narrow};
    end else begin : g_same
        assign wide = narrow[OUT_W-1:0];
    end

endmodule

// File: rtl/addsub_ovf.sv
module addsub_ovf
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    input  logic               sub_mode,
    output logic [WIDTH-1:0]   result,
    output logic               carry_out,
    output logic               overflow,
    output logic [2*WIDTH-1:0] result_wide
);

    localparam int MSB    = WIDTH - 1;
    localparam int WIDE_W = 2 * WIDTH;

    op_mode_e         mode;
    logic [WIDTH-1:0] b_eff;
    logic             cin_eff;
    logic [WIDTH:0]   carry_vec;

    assign mode = op_mode_e'(sub_mode);

    operand_prep #(.WIDTH(WIDTH)) u_prep (
        .raw_b     (op_b),
        .mode      (mode),
        .chain_b   (b_eff),
        .chain_cin (cin_eff)
    );

    ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .in_a    (op_a),
        .in_b    (b_eff),
        .cin     (cin_eff),
        .sum     (result),
        .carries (carry_vec)
    );

    assign carry_out = carry_vec[WIDTH];
    assign overflow  = carry_vec[MSB] ^ carry_vec[WIDTH];

    sign_widen #(.IN_W(WIDTH), .OUT_W(WIDE_W)) u_widen (
        .narrow (result),
        .wide   (result_wide)
    );

    always_comb begin
        // R4
        mixed_sign_no_ovf_chk: assert (!(!sub_mode && (op_a[MSB] != op_b[MSB]) && overflow));
        // R3
        ovf_sign_flip_chk: assert (!overflow || (result[MSB] != op_a[MSB]));
        // R6
        sub_zero_carry_chk: assert (!(sub_mode && (op_b == '0)) || carry_out);
        // R7
        widen_low_chk: assert (result_wide[WIDTH-1:0] == result);
    end

endmodule

// File: tb/test_addsub_ovf.sv
module test_addsub_ovf;

    localparam int W  = 4;
    localparam int NV = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0]   a, b;
    logic           sub;
    logic [W-1:0]   res;
    logic           cout, ovf;
    logic [2*W-1:0] wide;

    addsub_ovf #(.WIDTH(W)) i_addsub_ovf (
        .op_a (a), .op_b (b), .sub_mode (sub),
        .result (res), .carry_out (cout), .overflow (ovf), .result_wide (wide)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // row: sub, a, b, expected result, expected carry, expected overflow
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 4'h5, 4'h5, 4'hA, 1'b0, 1'b1},
        {1'b0, 4'hC, 4'hB, 4'h7, 1'b1, 1'b1},
        {1'b0, 4'h5, 4'hA, 4'hF, 1'b0, 1'b0},
        {1'b0, 4'hB, 4'hE, 4'h9, 1'b1, 1'b0},
        {1'b0, 4'h7, 4'h1, 4'h8, 1'b0, 1'b1},
        {1'b1, 4'h0, 4'h8, 4'h8, 1'b0, 1'b1},
        {1'b1, 4'h7, 4'hF, 4'h8, 1'b0, 1'b1},
        {1'b1, 4'h8, 4'h1, 4'h7, 1'b1, 1'b1},
        {1'b1, 4'h3, 4'h3, 4'h0, 1'b1, 1'b0},
        {1'b1, 4'hF, 4'hF, 4'h0, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h sub=%b actual=%h expected=%h", tag, a, b, sub, got, exp);
        end
    endtask

    task automatic apply(input logic s, input logic [W-1:0] x, input logic [W-1:0] y);
        @(posedge clk);
        sub = s; a = x; b = y;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (!done && ($time > 64'd1_000_000)) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        sub = 1'b0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state with idle operands: R1 R7
        check("R1 idle result", 16'(res), 16'h0);
        check("R5 idle carry", 16'(cout), 16'h0);
        check("R3 idle overflow", 16'(ovf), 16'h0);
        check("R7 idle wide", 16'(wide), 16'h0);
        rst_n = 1'b1;

        // directed table: R3 R4 R8 boundaries
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][14], VEC[i][13:10], VEC[i][9:6]);
            check(VEC[i][14] ? "R2 table result" : "R1 table result", 16'(res), 16'(VEC[i][5:2]));
            check(VEC[i][14] ? "R6 table carry" : "R5 table carry", 16'(cout), 16'(VEC[i][1]));
            check(VEC[i][14] ? "R8 table overflow" : "R3 table overflow", 16'(ovf), 16'(VEC[i][0]));
        end

        // exhaustive sweep against integer arithmetic
        for (int s = 0; s < 2; s++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    int sa, sb, tr;
                    logic [W-1:0] er;
                    logic ec, eo;
                    sa = (x >= 8) ? x - 16 : x;
                    sb = (y >= 8) ? y - 16 : y;
                    tr = (s == 1) ? sa - sb : sa + sb;
                    er = tr[W-1:0];
                    eo = (tr < -8) || (tr > 7);
                    ec = (s == 1) ? (x >= y) : ((x + y) >= 16);
                    apply(s[0], x[W-1:0], y[W-1:0]);
                    check(s == 1 ? "R2 result" : "R1 result", 16'(res), 16'(er));
                    check("R3 overflow", 16'(ovf), 16'(eo));
                    check(s == 1 ? "R6 carry" : "R5 carry", 16'(cout), 16'(ec));
                    check("R7 wide", 16'(wide), 16'({{W{er[W-1]}}, er}));
                    if (s == 0 && sa * sb < 0)
                        check("R4 mixed signs", 16'(ovf), 16'h0);
                    if (s == 1 && y == 8 && x < 8)
                        check("R8 minus most negative", 16'(ovf), 16'h1);
                end
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule